// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. The bus has a byte address, a write strobe, 32-bit write data and combinational read data. The bus has no back-pressure: every write is accepted in the cycle its strobe is high, and the read data follows the address in the same cycle. Software writes a configuration word once after power-on. That word sets a 16-bit reload count, the enable, a clock prescale choice, the expiry action and a debug freeze option. After that write the configuration is locked until the next reset.

Once enabled, a down-counter counts prescaled ticks. Software keeps the system alive by writing two key values in order to a 16-bit service register. Only the complete ordered pair reloads the counter. If the counter runs out, the block either sends a fixed-length reset pulse or sets a sticky interrupt, depending on the configuration. The timeout in seconds is the reload count times the prescale division, divided by the clock frequency.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control word reads 0xFFFF0000 (reload count 0xFFFF, all flag bits 0), the count register reads 0x0000FFFF, and both the interrupt and the reset pulse are low.
- R2: The control word is at byte address 0x04, with reload count in bits 31:16, freeze in bit 3, enable in bit 2, expiry action in bit 1 (1 = reset pulse, 0 = interrupt) and prescale select in bit 0. The first write to it is stored as written, reads back unchanged, and loads the counter with the new reload count. Reads of unmapped addresses return zero.
- R3: After the first control write, every later control write is ignored. Reading bit 2 back returns the locked enable, so an enable that was refused stays visible as 0.
- R4: The count register at 0x08 returns the counter in bits 15:0, with zeros above. Writes to it do not change the counter.
- R5: Writing 0x556C to the service register (address 0x0E, value in write-data bits 15:0) and then 0xAA39 as the next service write reloads the counter from the reload count and restarts the prescaler in that same clock edge.
- R6: Any service value other than the expected next key returns the key checker to idle without a reload. This includes a repeated 0x556C, or 0xAA39 with no 0x556C before it.
- R7: While enabled, the counter drops by one on each tick. A tick that finds the counter at 1 (or 0) is an expiry, and it reloads the counter, so one period is exactly reload-count ticks. While disabled, the counter holds and never expires.
- R8: With the expiry action at 0, an expiry sets the interrupt. The interrupt stays set until a complete key sequence reloads the counter or reset is applied.
- R9: With the expiry action at 1, an expiry drives the reset output high for exactly RST_CYCLES clocks, and the interrupt stays low.
- R10: With prescale select at 1, a tick occurs once every DIV clocks counted from the last reload. With prescale select at 0, every clock is a tick.
- R11: While the freeze bit is set and the debug-halt input is high, both the prescaler and the counter hold. The debug-halt input has no effect when freeze is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (8) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_halt | input | 1 | Debug halt request, synchronous to clk |
| wdt_irq | output | 1 | Sticky expiry interrupt |
| wdt_sys_rst | output | 1 | Expiry reset pulse |

## Verification
The assertions assume that the bus carries at most one write per cycle, so a control write and a service write never land in the same edge. They also assume that the debug-halt input is already synchronous to the clock. The bench drives the bus only through tasks that issue one access per cycle on the falling edge, and it changes the halt input on the falling edge as well. Random reload counts are kept between 2 and 40 and random waits stay inside one timeout period. This keeps every expected count value computable from the elapsed clock count and the prescale division alone.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0]  OFS_CTRL  = 8'h04;
  localparam logic [7:0]  OFS_COUNT = 8'h08;
  localparam logic [7:0]  OFS_SVC   = 8'h0E;
  localparam logic [15:0] KEY_A     = 16'h556C;
  localparam logic [15:0] KEY_B     = 16'hAA39;

  typedef struct packed {
    logic [15:0] reload;
    logic        freeze;
    logic        enable;
    logic        rst_sel;
    logic        pre_sel;
  } wdt_cfg_t;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [15:0] RST_COUNT = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic [15:0]   count,
  output wdt_cfg_t      cfg_q,
  output logic          cfg_load,
  output logic [15:0]   new_reload,
  output logic          svc_wr,
  output logic [15:0]   svc_data,
  output logic [31:0]   bus_rdata
);
  logic     locked_q;
  wdt_cfg_t cfg_d;

  always_comb begin
    cfg_d.reload  = bus_wdata[31:16];
    cfg_d.freeze  = bus_wdata[3];
    cfg_d.enable  = bus_wdata[2];
    cfg_d.rst_sel = bus_wdata[1];
    cfg_d.pre_sel = bus_wdata[0];
  end

  assign cfg_load   = bus_wr && (bus_addr == AW'(OFS_CTRL)) && !locked_q;
  assign new_reload = bus_wdata[31:16];
  assign svc_wr     = bus_wr && (bus_addr == AW'(OFS_SVC));
  assign svc_data   = bus_wdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cfg_q    <= '{reload: RST_COUNT, default: 1'b0};
    end else if (cfg_load) begin
      locked_q <= 1'b1;
      cfg_q    <= cfg_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_CTRL))
      bus_rdata = {cfg_q.reload, 12'h000, cfg_q.freeze, cfg_q.enable,
                   cfg_q.rst_sel, cfg_q.pre_sel};
    else if (bus_addr == AW'(OFS_COUNT))
      bus_rdata = {16'h0000, count};
  end

  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/kwdt_keychk.sv
module kwdt_keychk
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] svc_data,
  output logic        svc_reload
);
  key_state_e state_q;

  assign svc_reload = svc_wr && (state_q == KS_ARMED) && (svc_data == KEY_B);

  always_ff @(posedge clk) begin
    if (!rst_n)
      state_q <= KS_IDLE;
    else if (svc_wr)
      state_q <= (state_q == KS_IDLE && svc_data == KEY_A) ? KS_ARMED : KS_IDLE;
  end

  AST_IDLE_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    svc_reload |=> (state_q == KS_IDLE)); // R6
endmodule

// File: rtl/kwdt_presc.sv
module kwdt_presc #(
  parameter int DIV = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pre_sel,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  assign tick = run && (!pre_sel || pcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      pcnt_q <= '0;
    else if (run && pre_sel)
      pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
  end

  AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_sel && !restart && pcnt_q == LAST) |=> (pcnt_q == '0)); // R10
  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pcnt_q)); // R11
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int          CW         = 16,
  parameter int          RST_CYCLES = 4,
  parameter logic [15:0] RST_COUNT  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] reload_cur,
  input  logic [CW-1:0] reload_new,
  input  logic          cfg_load,
  input  logic          svc_reload,
  input  logic          rst_sel,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          irq,
  output logic          sys_rst
);
  logic [CW-1:0] cnt_q;
  logic          irq_q;
  logic          expire;

  assign expire = tick && !cfg_load && !svc_reload && (cnt_q <= CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= CW'(RST_COUNT);
    else if (cfg_load)   cnt_q <= reload_new;
    else if (svc_reload) cnt_q <= reload_cur;
    else if (tick)       cnt_q <= expire ? reload_cur : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || svc_reload)   irq_q <= 1'b0;
    else if (expire && !rst_sel) irq_q <= 1'b1;
  end

  generate
    if (RST_CYCLES <= 1) begin : g_pulse_one
      logic pulse_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= expire && rst_sel;
      end
      assign sys_rst = pulse_q;
    end else begin : g_pulse_multi
      localparam int PCW = $clog2(RST_CYCLES + 1);
      logic [PCW-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (!rst_n)               pc_q <= '0;
        else if (expire && rst_sel) pc_q <= PCW'(RST_CYCLES);
        else if (pc_q != '0)      pc_q <= pc_q - 1'b1;
      end
      assign sys_rst = (pc_q != '0);
    end
  endgenerate

  assign count = cnt_q;
  assign irq   = irq_q;

  AST_SVC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_reload |=> (cnt_q == $past(reload_cur))); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !svc_reload) |=> irq_q); // R8
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          DIV        = 65536,
  parameter int          RST_CYCLES = 4,
  parameter logic [15:0] RST_COUNT  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          dbg_halt,
  output logic          wdt_irq,
  output logic          wdt_sys_rst
);
  wdt_cfg_t    cfg;
  logic        cfg_load, svc_wr, svc_reload, tick, hold, run;
  logic [15:0] new_reload, svc_data, count;

  assign hold = cfg.freeze && dbg_halt;
  assign run  = cfg.enable && !hold;

  kwdt_regs #(.AW(AW), .RST_COUNT(RST_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .count(count), .cfg_q(cfg), .cfg_load(cfg_load),
    .new_reload(new_reload), .svc_wr(svc_wr), .svc_data(svc_data),
    .bus_rdata(bus_rdata));

  kwdt_keychk u_key (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(svc_data),
    .svc_reload(svc_reload));

  kwdt_presc #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(cfg.pre_sel),
    .restart(cfg_load || svc_reload), .tick(tick));

  kwdt_counter #(.CW(16), .RST_CYCLES(RST_CYCLES), .RST_COUNT(RST_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload_cur(cfg.reload), .reload_new(new_reload),
    .cfg_load(cfg_load), .svc_reload(svc_reload), .rst_sel(cfg.rst_sel),
    .tick(tick), .count(count), .irq(wdt_irq), .sys_rst(wdt_sys_rst));

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cfg_load && !svc_reload) |=> $stable(count)); // R11
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.enable && !cfg_load && !svc_reload) |=> $stable(count)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_irq && wdt_sys_rst)); // R9
endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  localparam int DIV  = 8;
  localparam int RSTC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        wdt_irq, wdt_sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kwdt_top #(.AW(8), .DIV(DIV), .RST_CYCLES(RSTC), .RST_COUNT(16'hFFFF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst));

  function automatic logic [31:0] mk_ctrl(input logic [15:0] r, input bit frz,
                                          input bit en, input bit rs, input bit ps);
    return {r, 12'h000, frz, en, rs, ps};
  endfunction

  function automatic logic [31:0] exp_cnt(input int r, input int j, input bit ps);
    return 32'(r - (ps ? j / DIV : j));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; dbg_halt = 1'b0;
    waitc(2);
    rst_n = 1'b1;
  endtask

  task automatic service();
    wr(8'h0E, 32'h0000_556C);
    wr(8'h0E, 32'h0000_AA39);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7719));
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(8'h04, d); chk("R1 ctrl", d, 32'hFFFF_0000);
    rd(8'h08, d); chk("R1 count", d, 32'h0000_FFFF);
    chk("R1 irq", {31'b0, wdt_irq}, 0);
    chk("R1 rst", {31'b0, wdt_sys_rst}, 0);
    rd(8'h00, d); chk("R2 unmapped", d, 0);

    // R2 first write, interrupt mode, no prescale, reload 10
    wr(8'h04, mk_ctrl(16'd10, 0, 1, 0, 0));
    rd(8'h04, d); chk("R2 ctrl readback", d, mk_ctrl(16'd10, 0, 1, 0, 0));
    rd(8'h08, d); chk("R2 count loaded", d, 10);
    // R3 later write ignored (consumes one edge: count 9)
    wr(8'h04, mk_ctrl(16'd50, 1, 0, 1, 1));
    rd(8'h04, d); chk("R3 locked", d, mk_ctrl(16'd10, 0, 1, 0, 0));
    rd(8'h08, d); chk("R3 still counts", d, 9);
    // R4 count write ignored
    wr(8'h08, 32'h0000_1234);
    rd(8'h08, d); chk("R4 write ignored", d, 8);
    // R5 key sequence
    waitc(3);
    rd(8'h08, d); chk("R7 decrement", d, 5);
    wr(8'h0E, 32'h0000_556C);
    rd(8'h08, d); chk("R6 half key no reload", d, 4);
    wr(8'h0E, 32'h0000_AA39);
    rd(8'h08, d); chk("R5 reload", d, 10);
    // R6 wrong sequences
    wr(8'h0E, 32'h0000_556C); wr(8'h0E, 32'h0000_1234); wr(8'h0E, 32'h0000_AA39);
    rd(8'h08, d); chk("R6 bad middle", d, 7);
    service();
    wr(8'h0E, 32'h0000_556C); wr(8'h0E, 32'h0000_556C); wr(8'h0E, 32'h0000_AA39);
    rd(8'h08, d); chk("R6 repeated first key", d, 7);
    service();
    wr(8'h0E, 32'h0000_AA39);
    rd(8'h08, d); chk("R6 lone second key", d, 9);
    // R11 halt without freeze has no effect
    service();
    dbg_halt = 1'b1; waitc(3); dbg_halt = 1'b0;
    rd(8'h08, d); chk("R11 halt ignored", d, 7);
    // R7/R8 expiry to interrupt
    service();
    waitc(9);
    rd(8'h08, d); chk("R7 count at 1", d, 1);
    chk("R8 irq before", {31'b0, wdt_irq}, 0);
    waitc(1);
    chk("R8 irq set", {31'b0, wdt_irq}, 1);
    rd(8'h08, d); chk("R7 reload on expiry", d, 10);
    chk("R9 no rst in irq mode", {31'b0, wdt_sys_rst}, 0);
    waitc(15);
    chk("R8 irq sticky", {31'b0, wdt_irq}, 1);
    wr(8'h0E, 32'h0000_556C);
    chk("R8 irq kept by half key", {31'b0, wdt_irq}, 1);
    wr(8'h0E, 32'h0000_AA39);
    chk("R8 irq cleared", {31'b0, wdt_irq}, 0);

    // R9 reset mode
    do_reset();
    wr(8'h04, mk_ctrl(16'd4, 0, 1, 1, 0));
    waitc(3);
    chk("R9 rst low before", {31'b0, wdt_sys_rst}, 0);
    waitc(1);
    for (int i = 0; i < RSTC; i++) begin
      chk("R9 pulse high", {31'b0, wdt_sys_rst}, 1);
      chk("R9 irq low", {31'b0, wdt_irq}, 0);
      waitc(1);
    end
    chk("R9 pulse ended", {31'b0, wdt_sys_rst}, 0);

    // R7/R3 disabled: count holds, enable refused
    do_reset();
    wr(8'h04, mk_ctrl(16'd5, 0, 0, 0, 0));
    waitc(20);
    rd(8'h08, d); chk("R7 disabled holds", d, 5);
    chk("R7 disabled no irq", {31'b0, wdt_irq}, 0);
    wr(8'h04, mk_ctrl(16'd5, 0, 1, 0, 0));
    rd(8'h04, d); chk("R3 refused enable", {31'b0, d[2]}, 0);
    waitc(10);
    rd(8'h08, d); chk("R3 still held", d, 5);

    // R10 prescale with restart on service
    do_reset();
    wr(8'h04, mk_ctrl(16'd3, 0, 1, 0, 1));
    waitc(7);
    rd(8'h08, d); chk("R10 before first tick", d, 3);
    waitc(1);
    rd(8'h08, d); chk("R10 first tick", d, 2);
    waitc(5);
    wr(8'h0E, 32'h0000_556C);
    rd(8'h08, d); chk("R10 mid", d, 2);
    wr(8'h0E, 32'h0000_AA39);
    waitc(7);
    rd(8'h08, d); chk("R10 restart prescaler", d, 3);
    waitc(1);
    rd(8'h08, d); chk("R10 tick after restart", d, 2);
    waitc(15);
    chk("R10 no early expiry", {31'b0, wdt_irq}, 0);
    waitc(1);
    chk("R10 expiry at 24", {31'b0, wdt_irq}, 1);

    // R11 freeze with halt
    do_reset();
    wr(8'h04, mk_ctrl(16'd20, 1, 1, 0, 0));
    waitc(2);
    rd(8'h08, d); chk("R11 running", d, 18);
    dbg_halt = 1'b1; waitc(5);
    rd(8'h08, d); chk("R11 frozen", d, 18);
    dbg_halt = 1'b0; waitc(1);
    rd(8'h08, d); chk("R11 resumed", d, 17);

    // R7/R10 random runs
    for (int it = 0; it < 8; it++) begin
      int r, span, el, step;
      bit ps;
      r  = $urandom_range(2, 40);
      ps = 1'($urandom_range(0, 1));
      span = r * (ps ? DIV : 1);
      do_reset();
      wr(8'h04, mk_ctrl(16'(r), 0, 1, 0, ps));
      el = 0;
      for (int k = 0; k < 3; k++) begin
        step = $urandom_range(0, (span - 1 - el) / 2);
        waitc(step);
        el += step;
        rd(8'h08, d); chk("R7 random count", d, exp_cnt(r, el, ps));
      end
      service();
      rd(8'h08, d); chk("R5 random reload", d, 32'(r));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule